// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous page-mode DRAM interface. It samples the four active-low strobes (row strobe, column strobe, write enable, output enable) on a fast system clock. From the order in which their edges arrive, it works out which kind of memory cycle the controller is running. It reports a 4-bit cycle code, the row that the cycle refreshes or opens, and a decision on whether the data pins may be driven.

Three kinds of cycle open the row with the column strobe high: reads, the three write variants, and the refresh that uses only the row strobe. The column strobe and write enable then refine the code. When the column strobe is already low as the row strobe falls, the cycle is one of the counter-driven refresh family: a plain refresh, test-mode entry, hidden refresh after a read, or self refresh once the row strobe has been held low for long enough. For this family an internal row counter replaces the address pins. The counter advances once per refresh and wraps around. The strobes may be resynchronised by an optional flop chain chosen by parameter. The default has no resync stage, so every output follows the sampled strobes by exactly one clock.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, the cycle code is 0 (idle), dq_oe is 0 and ref_row is 0.
- R2: A row-strobe fall while the column strobe is high gives code 1 (row open), and ref_row captures the address pins at that edge.
- R3: If the row strobe rises again with no column-strobe fall since it fell, the code becomes 6 (row-only refresh). Write enable and output enable have no effect, and dq_oe stays 0.
- R4: A column-strobe fall with write enable already low gives code 3 (early write). dq_oe then stays 0 even when output enable goes low.
- R5: A column-strobe fall with write enable high gives code 2 (read). While the code is 2, dq_oe is 1 exactly when both the column strobe and output enable are low.
- R6: In a read, a write-enable fall while the column strobe is low, with output enable never low during that column access, gives code 4 (output-enable-controlled write) with dq_oe 0.
- R7: In a read, a write-enable fall at least WD_MIN clocks after the column-strobe fall, with output enable seen low, gives code 5 (read-modify-write). dq_oe stays 1 while the column strobe and output enable are low.
- R8: In a read, a write-enable fall fewer than WD_MIN clocks after the column-strobe fall, with output enable seen low, gives code 11 (indeterminate) with dq_oe 0.
- R9: A row-strobe fall with the column strobe low and write enable high gives code 7 (counter refresh). ref_row shows the internal counter, and the address pins are ignored.
- R10: A row-strobe fall with both the column strobe and write enable low gives code 10 (test-mode entry), and ref_row shows the counter.
- R11: The 11-bit refresh counter advances by one when the row strobe rises at the end of a cycle coded 7, 8, 9 or 10, and it wraps from 2047 to 0.
- R12: When a read ends with the row strobe rising while the column strobe stays low, a new row-strobe fall gives code 8 (hidden refresh). ref_row shows the counter, and dq_oe stays 1 throughout while output enable is low.
- R13: When the code is 7 and the row strobe has stayed low for SELF_CYC clocks (12500 by default), the code becomes 9 (self refresh).
- R14: While the row strobe stays low, the code changes only from 1, 2 or 7 as stated above. After the row strobe rises, the code holds until the next row-strobe fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address pins |
| cyc_code | output | 4 | Classified cycle code |
| ref_row | output | ROW_W | Row opened or refreshed by the current cycle |
| dq_oe | output | 1 | Data pins may be driven |

## Verification
The bench concentrates on the timing of the write-enable fall against the column-strobe fall. It places the fall exactly at WD_MIN clocks and just below it, so an off-by-one age counter would report read-modify-write where indeterminate is expected, or the other way round. It walks the refresh counter through its wrap and holds the row strobe low for one clock less than the self-refresh threshold and then past it, which exposes a counter that fails to wrap or a threshold that fires early. A hidden refresh is run with the column strobe held low through the row-strobe gap, which catches a design that drops the read data or treats the cycle as a plain counter refresh. Early writes are followed by output enable going low, to show that the pins are never driven in that case.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   typedef enum logic [3:0] {
      CY_IDLE     = 4'd0,
      CY_ACTIVE   = 4'd1,
      CY_READ     = 4'd2,
      CY_EARLY_WR = 4'd3,
      CY_OE_WR    = 4'd4,
      CY_RMW      = 4'd5,
      CY_ROW_REF  = 4'd6,
      CY_CBR      = 4'd7,
      CY_HIDDEN   = 4'd8,
      CY_SELF     = 4'd9,
      CY_TEST     = 4'd10,
      CY_INDET    = 4'd11
   } cyc_e;

   typedef struct packed {
      logic ras;
      logic cas;
      logic we;
      logic oe;
   } strobe_t;

endpackage

// File: rtl/dcc_strobe_sync.sv
module dcc_strobe_sync
   import dcc_pkg::*;
#(
   parameter int STAGES = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  strobe_t raw_i,
   output strobe_t sync_o
);

   generate
      if (STAGES < 0 || STAGES > 3) begin : g_bad
         $error("dcc_strobe_sync: STAGES must be 0..3");
      end

      if (STAGES == 0) begin : g_direct
         assign sync_o = raw_i;
      end else begin : g_chain
         strobe_t chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= '1;
            end else begin
               chain_q[0] <= raw_i;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign sync_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dcc_refresh_ctr.sv
module dcc_refresh_ctr #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = '1;

   generate
      if (W < 1 || W > 16) begin : g_bad
         $error("dcc_refresh_ctr: W must be 1..16");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R11
   ctr_moves_on_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q) |-> $past(inc));

   // R11
   ctr_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inc) && $past(cnt_q) == TOP) |-> cnt_q == '0);

endmodule

// File: rtl/dcc_classifier.sv
module dcc_classifier
   import dcc_pkg::*;
#(
   parameter int ROW_W    = 11,
   parameter int WD_MIN   = 4,
   parameter int SELF_CYC = 12500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  strobe_t          s,
   input  logic [ROW_W-1:0] addr,
   input  logic [ROW_W-1:0] ctr_row,
   output logic             ctr_inc,
   output logic [3:0]       code,
   output logic [ROW_W-1:0] row,
   output logic             dq_oe
);

   localparam int AGE_W = $clog2(WD_MIN + 1);
   localparam int SR_W  = $clog2(SELF_CYC + 1);
   localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(WD_MIN);
   localparam logic [SR_W-1:0]  SR_LIM  = SR_W'(SELF_CYC);

   generate
      if (WD_MIN < 1) begin : g_bad_wd
         $error("dcc_classifier: WD_MIN must be at least 1");
      end
      if (SELF_CYC < 2) begin : g_bad_sr
         $error("dcc_classifier: SELF_CYC must be at least 2");
      end
   endgenerate

   // previous samples of the strobes, idle high out of reset
   logic ras_p, cas_p, we_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_p <= 1'b1;
         cas_p <= 1'b1;
         we_p  <= 1'b1;
      end else begin
         ras_p <= s.ras;
         cas_p <= s.cas;
         we_p  <= s.we;
      end
   end

   logic ras_fall, ras_rise, cas_fall, we_fall;
   assign ras_fall = ras_p & ~s.ras;
   assign ras_rise = ~ras_p & s.ras;
   assign cas_fall = cas_p & ~s.cas;
   assign we_fall  = we_p & ~s.we;

   cyc_e             code_q, code_d;
   logic [AGE_W-1:0] age_q;
   logic [SR_W-1:0]  sr_q;
   logic             oe_seen_q;
   logic             hold_q;
   logic [ROW_W-1:0] row_q;
   logic             dq_oe_q;

   // column age and output-enable history of the current column access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q     <= '0;
         oe_seen_q <= 1'b0;
      end else if (cas_fall) begin
         age_q     <= AGE_W'(1);
         oe_seen_q <= ~s.oe;
      end else if (!s.cas) begin
         if (age_q < AGE_LIM) age_q <= age_q + 1'b1;
         if (!s.oe) oe_seen_q <= 1'b1;
      end
   end

   // row-strobe low time for the self-refresh threshold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          sr_q <= '0;
      else if (ras_fall)                                   sr_q <= SR_W'(1);
      else if (code_q == CY_CBR && !s.ras && sr_q < SR_LIM) sr_q <= sr_q + 1'b1;
   end

   // read left open across a row-strobe gap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                           hold_q <= 1'b0;
      else if (s.cas)                                                       hold_q <= 1'b0;
      else if (ras_rise && (code_q == CY_READ || code_q == CY_HIDDEN))      hold_q <= 1'b1;
   end

   logic oe_low_now;
   assign oe_low_now = oe_seen_q | ~s.oe;

   always_comb begin
      code_d = code_q;
      if (ras_fall) begin
         if (!s.cas) begin
            if (hold_q)     code_d = CY_HIDDEN;
            else if (!s.we) code_d = CY_TEST;
            else            code_d = CY_CBR;
         end else begin
            code_d = CY_ACTIVE;
         end
      end else if (!s.ras) begin
         unique case (code_q)
            CY_ACTIVE: begin
               if (cas_fall) code_d = s.we ? CY_READ : CY_EARLY_WR;
            end
            CY_READ: begin
               if (we_fall && !s.cas) begin
                  if (!oe_low_now)           code_d = CY_OE_WR;
                  else if (age_q >= AGE_LIM) code_d = CY_RMW;
                  else                       code_d = CY_INDET;
               end
            end
            CY_CBR: begin
               if (sr_q >= SR_LIM) code_d = CY_SELF;
            end
            default: code_d = code_q;
         endcase
      end else if (ras_rise && code_q == CY_ACTIVE) begin
         code_d = CY_ROW_REF;
      end
   end

   logic drives_data;
   assign drives_data = (code_d == CY_READ) || (code_d == CY_RMW) || (code_d == CY_HIDDEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= CY_IDLE;
         row_q   <= '0;
         dq_oe_q <= 1'b0;
      end else begin
         code_q  <= code_d;
         dq_oe_q <= drives_data & ~s.cas & ~s.oe;
         if (ras_fall) row_q <= s.cas ? addr : ctr_row;
      end
   end

   assign ctr_inc = ras_rise && (code_q == CY_CBR || code_q == CY_HIDDEN ||
                                 code_q == CY_SELF || code_q == CY_TEST);
   assign code  = code_q;
   assign row   = row_q;
   assign dq_oe = dq_oe_q;

   // R14
   code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s.ras && !ras_p && !(code_q inside {CY_IDLE, CY_ACTIVE, CY_READ, CY_CBR}))
      |=> code_q == $past(code_q));

   // R5
   drive_only_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_q |-> (code_q inside {CY_READ, CY_RMW, CY_HIDDEN}));

   // R4
   early_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == CY_EARLY_WR) |-> !dq_oe_q);

   // R13
   self_from_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == CY_SELF && $past(code_q) != CY_SELF) |-> $past(code_q) == CY_CBR);

   // R12
   hidden_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == CY_HIDDEN && $past(code_q) != CY_HIDDEN) |-> $past(hold_q));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
   import dcc_pkg::*;
#(
   parameter int ROW_W       = 11,
   parameter int WD_MIN      = 4,
   parameter int CLK_MHZ     = 125,
   parameter int SELF_US     = 100,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [ROW_W-1:0] addr,
   output logic [3:0]       cyc_code,
   output logic [ROW_W-1:0] ref_row,
   output logic             dq_oe
);

   localparam int SELF_CYC = CLK_MHZ * SELF_US;

   strobe_t raw, sync;
   logic [ROW_W-1:0] ctr_row;
   logic             ctr_inc;

   assign raw = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};

   dcc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw),
      .sync_o (sync)
   );

   dcc_refresh_ctr #(.W(ROW_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc),
      .cnt   (ctr_row)
   );

   dcc_classifier #(
      .ROW_W    (ROW_W),
      .WD_MIN   (WD_MIN),
      .SELF_CYC (SELF_CYC)
   ) u_cls (
      .clk     (clk),
      .rst_n   (rst_n),
      .s       (sync),
      .addr    (addr),
      .ctr_row (ctr_row),
      .ctr_inc (ctr_inc),
      .code    (cyc_code),
      .row     (ref_row),
      .dq_oe   (dq_oe)
   );

endmodule

// File: tb/sim_dram_cycle_classifier.sv
`timescale 1ns/1ps
module sim_dram_cycle_classifier;

   localparam int ROW_W    = 11;
   localparam int WD_MIN   = 4;
   localparam int SELF_CYC = 125 * 100;
   localparam int ROWS     = 1 << ROW_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [ROW_W-1:0] addr = '0;
   logic [3:0]       cyc_code;
   logic [ROW_W-1:0] ref_row;
   logic             dq_oe;

   always #4 clk = ~clk;

   dram_cycle_classifier #(.ROW_W(ROW_W), .WD_MIN(WD_MIN)) u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .cyc_code(cyc_code), .ref_row(ref_row), .dq_oe(dq_oe)
   );

   int checks = 0;
   int errors = 0;
   int ctr_exp = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int code_of(int kind);
      case (kind)
         0: return 2;
         1: return 3;
         2: return 4;
         3: return 5;
         4: return 11;
         default: return 6;
      endcase
   endfunction

   task automatic idle_all();
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   // kinds: 0 read, 1 early write, 2 oe write, 3 rmw, 4 indeterminate, 5 row-only refresh
   task automatic normal_cycle(int kind, logic [ROW_W-1:0] row, int d);
      ras_n = 1'b0; addr = row;
      step(1);
      chk("R2 open code", cyc_code, 1);
      chk("R2 row", ref_row, row);
      addr = ~row;
      step(d);
      case (kind)
         5: begin
            we_n = 1'($urandom % 2); oe_n = 1'($urandom % 2);
            step(1);
            ras_n = 1'b1;
            step(1);
            chk("R3 code", cyc_code, 6);
            chk("R3 dq_oe", dq_oe, 0);
         end
         1: begin
            we_n = 1'b0; cas_n = 1'b0;
            step(1);
            chk("R4 code", cyc_code, 3);
            oe_n = 1'b0;
            step(1);
            chk("R4 dq_oe", dq_oe, 0);
         end
         0: begin
            cas_n = 1'b0;
            step(1);
            chk("R5 code", cyc_code, 2);
            chk("R5 dq_oe oe high", dq_oe, 0);
            oe_n = 1'b0;
            step(1);
            chk("R5 dq_oe oe low", dq_oe, 1);
         end
         2: begin
            cas_n = 1'b0;
            step(1 + d);
            we_n = 1'b0;
            step(1);
            chk("R6 code", cyc_code, 4);
            chk("R6 dq_oe", dq_oe, 0);
         end
         3: begin
            cas_n = 1'b0; oe_n = 1'b0;
            step(WD_MIN + d);
            we_n = 1'b0;
            step(1);
            chk("R7 code", cyc_code, 5);
            chk("R7 dq_oe", dq_oe, 1);
         end
         default: begin
            cas_n = 1'b0; oe_n = 1'b0;
            step(1 + (d % (WD_MIN - 1)));
            we_n = 1'b0;
            step(1);
            chk("R8 code", cyc_code, 11);
            chk("R8 dq_oe", dq_oe, 0);
         end
      endcase
      idle_all();
      step(1);
      chk("R14 held after rise", cyc_code, code_of(kind));
      step(1);
   endtask

   task automatic cbr(bit test, int hold);
      cas_n = 1'b0; we_n = test ? 1'b0 : 1'b1; addr = ROW_W'($urandom);
      step(1);
      ras_n = 1'b0;
      step(1);
      if (test) chk("R10 code", cyc_code, 10);
      else      chk("R9 code", cyc_code, 7);
      chk("R9 R11 counter row", ref_row, ctr_exp);
      step(hold);
      ras_n = 1'b1;
      step(1);
      ctr_exp = (ctr_exp + 1) % ROWS;
      cas_n = 1'b1; we_n = 1'b1;
      step(1);
   endtask

   bit done = 1'b0;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1d0c_0a55));
      step(2);
      chk("R1 code", cyc_code, 0);
      chk("R1 dq_oe", dq_oe, 0);
      chk("R1 row", ref_row, 0);
      rst_n = 1'b1;
      step(2);

      // directed: each normal kind, W fall exactly at and just below the limit
      for (int k = 0; k < 6; k++) normal_cycle(k, ROW_W'(100 + k), 0);
      normal_cycle(3, ROW_W'(7), 0);
      normal_cycle(4, ROW_W'(8), WD_MIN - 2);

      // refresh family
      cbr(1'b0, 3);
      cbr(1'b1, 1);

      // hidden refresh after a read
      ras_n = 1'b0; addr = ROW_W'(55);
      step(1);
      cas_n = 1'b0;
      step(1);
      oe_n = 1'b0;
      step(1);
      chk("R5 read drive", dq_oe, 1);
      ras_n = 1'b1;
      step(1);
      chk("R12 gap code", cyc_code, 2);
      chk("R12 gap dq_oe", dq_oe, 1);
      ras_n = 1'b0;
      step(1);
      chk("R12 code", cyc_code, 8);
      chk("R12 row", ref_row, ctr_exp);
      chk("R12 dq_oe", dq_oe, 1);
      step(2);
      ras_n = 1'b1;
      step(1);
      ctr_exp = (ctr_exp + 1) % ROWS;
      chk("R12 dq_oe after", dq_oe, 1);
      idle_all();
      step(1);
      chk("R12 release", dq_oe, 0);
      step(1);

      // self refresh threshold
      cas_n = 1'b0;
      step(1);
      ras_n = 1'b0;
      step(1);
      step(SELF_CYC - 2);
      chk("R13 below limit", cyc_code, 7);
      step(2);
      chk("R13 code", cyc_code, 9);
      ras_n = 1'b1;
      step(1);
      ctr_exp = (ctr_exp + 1) % ROWS;
      cas_n = 1'b1;
      step(1);

      // constrained random mix
      for (int i = 0; i < 200; i++) begin
         int sel;
         sel = int'($urandom % 8);
         if (sel < 6) normal_cycle(sel, ROW_W'($urandom), int'($urandom % 3));
         else         cbr(sel == 7, int'($urandom % 4));
      end

      // counter wrap
      while (ctr_exp != ROWS - 1) cbr(1'b0, 0);
      cbr(1'b0, 0);
      chk("R11 wrapped expected", ctr_exp, 0);
      cbr(1'b0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule